// File: doc/BRIEF.md
# Tag Working-State Power Controller

This block sequences the digital core of a passive tag through five working phases and decides, phase by phase, which sub-units receive an enable. After reset the core sits in a boot phase. Once the analog supply reports that it is good, a copy engine moves the non-volatile contents into a low-power volatile shadow, so that later reads do not cause current peaks. The core then idles with only the symbol detector running. When a reader message begins, the command decoder joins the detector. When the message ends, both are switched off and the control logic with its register bank runs for a fixed number of cycles. The transmitter then sends the reply, and the core returns to idle.

The state code and every enable come straight from flip-flops. The gated units therefore see clean, glitch-free levels, and each enable changes on the same clock edge as the state it belongs to. An event pulse that arrives in a phase which does not expect it changes nothing.

Top module: `tag_pwr_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next clock edge sets the state code to 0 and drives all five enables low.
- R2: The state code is 3 bits wide, with boot=0, idle=1, receive=2, control=3 and transmit=4. No other value ever appears.
- R3: The enables are set by the state alone. In boot, only the copy enable may be high, and only while `pwr_good` is high. In idle, only the detector enable is high. In receive, only the detector and decoder enables are high. In control, only the control enable is high. In transmit, only the transmitter enable is high.
- R4: Boot is left for idle on the clock edge where `copy_done` and `pwr_good` are both high. Otherwise the state stays in boot.
- R5: In idle, a high `msg_start` moves the state to receive on the next edge.
- R6: In receive, a high `msg_end` moves the state to control on the next edge. On that same edge the detector and decoder enables fall and the control enable rises.
- R7: Control lasts exactly `CTRL_CYCLES` clock cycles, and the state then moves to transmit without any input.
- R8: In transmit, a high `resp_done` moves the state to idle on the next edge.
- R9: Each event input has no effect outside the state that consumes it. This covers `msg_start` outside idle, `msg_end` outside receive, `resp_done` outside transmit, and `copy_done` outside boot.
- R10: The state code and the enables change on the same clock edge. No sample ever shows enables that belong to a different state than the code shown with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply settled after power-on reset |
| copy_done | input | 1 | Shadow copy finished |
| msg_start | input | 1 | Start of a reader message detected |
| msg_end | input | 1 | Whole reader message received |
| resp_done | input | 1 | Reply transmission finished |
| state | output | 3 | Working-state code |
| en_detect | output | 1 | Symbol detector enable |
| en_decode | output | 1 | Command decoder enable |
| en_control | output | 1 | Control logic and register bank enable |
| en_xmit | output | 1 | Transmitter enable |
| en_copy | output | 1 | Memory copy engine enable |

## Verification
The bench builds the block with `CTRL_CYCLES` set to 3. A control phase that short is crossed many times in a long random run, so the exact hand-over from control to transmit is checked repeatedly. Event pulses fire at random in every phase. This stresses the rule that a pulse outside its own state is ignored, and occasional resets mid-sequence check that reset wins from every state.

// File: rtl/tag_pwr_pkg.sv
package tag_pwr_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_BOOT = 3'd0,
        ST_IDLE = 3'd1,
        ST_RECV = 3'd2,
        ST_CTRL = 3'd3,
        ST_XMIT = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic copier;
        logic xmit;
        logic ctrl;
        logic decoder;
        logic detector;
    } unit_en_t;

    localparam int NUM_UNITS = $bits(unit_en_t);

    // Which units run in a given working phase.
    function automatic unit_en_t units_for(pwr_state_e s, logic supply_ok);
        unit_en_t u;
        u = '0;
        case (s)
            ST_BOOT: u.copier   = supply_ok;
            ST_IDLE: u.detector = 1'b1;
            ST_RECV: begin
                u.detector = 1'b1;
                u.decoder  = 1'b1;
            end
            ST_CTRL: u.ctrl     = 1'b1;
            ST_XMIT: u.xmit     = 1'b1;
            default: u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/tag_pwr_ctrl_timer.sv
module tag_pwr_ctrl_timer #(
    parameter int CTRL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expire
);
    localparam int CNT_W = $clog2(CTRL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = active && (cnt_q == LAST);

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/tag_pwr_seq.sv
module tag_pwr_seq
    import tag_pwr_pkg::*;
(
    input  pwr_state_e cur,
    input  logic       pwr_good,
    input  logic       copy_done,
    input  logic       msg_start,
    input  logic       msg_end,
    input  logic       resp_done,
    input  logic       ctrl_expire,
    output pwr_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_BOOT: if (copy_done && pwr_good) nxt = ST_IDLE;
            ST_IDLE: if (msg_start)             nxt = ST_RECV;
            ST_RECV: if (msg_end)               nxt = ST_CTRL;
            ST_CTRL: if (ctrl_expire)           nxt = ST_XMIT;
            ST_XMIT: if (resp_done)             nxt = ST_IDLE;
            default:                            nxt = ST_BOOT;
        endcase
    end
endmodule

// File: rtl/tag_pwr_gate.sv
module tag_pwr_gate
    import tag_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pwr_state_e nxt,
    input  logic       pwr_good,
    output pwr_state_e state_q,
    output unit_en_t   en_q
);
    // State and enables share one edge, so both follow the same next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            en_q    <= '0;
        end else begin
            state_q <= nxt;
            en_q    <= units_for(nxt, pwr_good);
        end
    end

    // R3
    idle_units_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (en_q.detector && !en_q.decoder && !en_q.ctrl
                                  && !en_q.xmit && !en_q.copier));
    // R3
    boot_units_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT) |-> (!en_q.detector && !en_q.decoder && !en_q.ctrl
                                  && !en_q.xmit));
    // R10
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_q.copier, en_q.xmit, en_q.ctrl, en_q.detector}));
endmodule

// File: rtl/tag_pwr_ctrl.sv
module tag_pwr_ctrl
    import tag_pwr_pkg::*;
#(
    parameter int CTRL_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_good,
    input  logic               copy_done,
    input  logic               msg_start,
    input  logic               msg_end,
    input  logic               resp_done,
    output logic [STATE_W-1:0] state,
    output logic               en_detect,
    output logic               en_decode,
    output logic               en_control,
    output logic               en_xmit,
    output logic               en_copy
);
    pwr_state_e cur_q;
    pwr_state_e nxt;
    unit_en_t   en_q;
    logic       ctrl_expire;

    tag_pwr_ctrl_timer #(.CTRL_CYCLES(CTRL_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (cur_q == ST_CTRL),
        .expire (ctrl_expire)
    );

    tag_pwr_seq u_seq (
        .cur         (cur_q),
        .pwr_good    (pwr_good),
        .copy_done   (copy_done),
        .msg_start   (msg_start),
        .msg_end     (msg_end),
        .resp_done   (resp_done),
        .ctrl_expire (ctrl_expire),
        .nxt         (nxt)
    );

    tag_pwr_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .nxt      (nxt),
        .pwr_good (pwr_good),
        .state_q  (cur_q),
        .en_q     (en_q)
    );

    assign state      = cur_q;
    assign en_detect  = en_q.detector;
    assign en_decode  = en_q.decoder;
    assign en_control = en_q.ctrl;
    assign en_xmit    = en_q.xmit;
    assign en_copy    = en_q.copier;

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        state <= 3'd4);
    // R5
    start_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_IDLE && msg_start) |=> (cur_q == ST_RECV));
    // R6
    end_rx_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_RECV && msg_end) |=> (cur_q == ST_CTRL && !en_detect && !en_decode && en_control));
    // R8
    tx_done_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_XMIT && resp_done) |=> (cur_q == ST_IDLE));
    // R9
    stray_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q != ST_IDLE && cur_q != ST_RECV) |=> (cur_q != ST_RECV));
    // R4
    boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == ST_BOOT && !(copy_done && pwr_good)) |=> (cur_q == ST_BOOT));
endmodule

// File: tb/test_tag_pwr_ctrl.sv
module test_tag_pwr_ctrl;
    localparam int CTRL_N = 3;
    localparam int MAX_CYC = 20000;

    logic clk = 1'b0;
    logic rst, pwr_good, copy_done, msg_start, msg_end, resp_done;
    logic [2:0] state;
    logic en_detect, en_decode, en_control, en_xmit, en_copy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_state = 0;
    int m_cnt = 0;
    int m_en = 0;

    always #5 clk = ~clk;

    tag_pwr_ctrl #(.CTRL_CYCLES(CTRL_N)) i_tag_pwr_ctrl (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .copy_done(copy_done),
        .msg_start(msg_start), .msg_end(msg_end), .resp_done(resp_done),
        .state(state), .en_detect(en_detect), .en_decode(en_decode),
        .en_control(en_control), .en_xmit(en_xmit), .en_copy(en_copy)
    );

    // enable vector bits: copy=16 xmit=8 control=4 decode=2 detect=1
    function automatic int units_of(int s, bit good);
        case (s)
            0: return good ? 16 : 0;
            1: return 1;
            2: return 3;
            3: return 4;
            4: return 8;
            default: return 0;
        endcase
    endfunction

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        int nx;
        if (rst) begin
            m_state = 0; m_cnt = 0; m_en = 0;
        end else begin
            nx = m_state;
            if (m_state == 0 && copy_done && pwr_good) nx = 1;
            if (m_state == 1 && msg_start) nx = 2;
            if (m_state == 2 && msg_end) nx = 3;
            if (m_state == 4 && resp_done) nx = 1;
            if (m_state == 3) begin
                if (m_cnt == CTRL_N - 1) begin nx = 4; m_cnt = 0; end
                else m_cnt++;
            end else m_cnt = 0;
            m_state = nx;
            m_en = units_of(nx, pwr_good);
        end
    end

    function automatic int dut_en();
        return {en_copy, en_xmit, en_control, en_decode, en_detect};
    endfunction

    task automatic expect_eq(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_model();
        string tag;
        case (m_state)
            0: tag = "R4"; 1: tag = "R8"; 2: tag = "R5";
            3: tag = "R6"; 4: tag = "R7"; default: tag = "R2";
        endcase
        expect_eq(tag, int'(state), m_state);
        expect_eq("R3", dut_en(), m_en);
    endtask

    task automatic clear_ins();
        copy_done = 0; msg_start = 0; msg_end = 0; resp_done = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        clear_ins();
    endtask

    initial begin
        rst = 1; pwr_good = 0; clear_ins();
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect_eq("R1", int'(state), 0);
        expect_eq("R1", dut_en(), 0);
        rst = 0;

        msg_start = 1; step();
        expect_eq("R9", int'(state), 0);
        copy_done = 1; step();
        expect_eq("R4", int'(state), 0);
        pwr_good = 1; step();
        expect_eq("R4", int'(en_copy), 1);
        copy_done = 1; step();
        expect_eq("R4", int'(state), 1);
        expect_eq("R3", dut_en(), 1);
        msg_end = 1; resp_done = 1; step();
        expect_eq("R9", int'(state), 1);
        msg_start = 1; step();
        expect_eq("R5", int'(state), 2);
        expect_eq("R10", dut_en(), 3);
        msg_start = 1; resp_done = 1; copy_done = 1; step();
        expect_eq("R9", int'(state), 2);
        msg_end = 1; step();
        expect_eq("R6", int'(state), 3);
        expect_eq("R6", dut_en(), 4);
        step(); step();
        expect_eq("R7", int'(state), 3);
        step();
        expect_eq("R7", int'(state), 4);
        expect_eq("R10", dut_en(), 8);
        msg_start = 1; step();
        expect_eq("R9", int'(state), 4);
        resp_done = 1; step();
        expect_eq("R8", int'(state), 1);
        expect_eq("R2", int'(state), 1);

        for (int i = 0; i < 4000; i++) begin
            rst       = ($urandom_range(0, 299) == 0);
            pwr_good  = ($urandom_range(0, 9) != 0);
            copy_done = ($urandom_range(0, 3) == 0);
            msg_start = ($urandom_range(0, 3) == 0);
            msg_end   = ($urandom_range(0, 3) == 0);
            resp_done = ($urandom_range(0, 3) == 0);
            @(posedge clk);
            @(negedge clk);
            compare_model();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule